// File: doc/BRIEF.md
# PWM Clock Prescaler and Channel Gate

This block is the clock front end of a four-channel pulse-width timer. It divides the system clock by a programmable 8-bit divisor and then by a fixed two. The result is a one-cycle scaled tick in the system clock domain, not a derived clock. A divisor of zero counts as 256. A new divisor is loaded into the counter only at its next terminal count, so the period in progress always finishes with the old value.

A channel enable register drives two things. First, a per-channel gate passes scaled ticks to that channel's counter as a count strobe. Second, it takes over the direction of the channel's port pin. The gate changes state only on a scaled-clock edge, so a channel never sees a partial period. An enabled channel forces its pin to output and selects the waveform onto it. The external data-direction value is never modified and regains control when the enable clears.

Two test bits in the enable register can be written only while `test_mode` is high; when `test_mode` is low they are held at zero. One bit replaces the divisor readback with the scaled-clock level. The other exports a signal that stops period matches from resetting the channel counters.

Top module: `pwm_clkfront`

## Requirements
- R1: With a divisor value d from 1 to 255, `s_tick` is high for exactly one cycle and repeats every 2*d clock cycles once d is in effect.
- R2: A divisor value of 0 gives a tick period of 512 clock cycles.
- R3: After reset both registers read 0x00, and `s_tick`, `ch_tick`, `pin_oe`, `pin_pwm_sel` and `cmp_reset_inhibit` are all 0.
- R4: `rd_data` is registered. One cycle after `reg_sel` is presented, it shows the divisor register (`reg_sel`=0) or the enable register (`reg_sel`=1). The enable register image holds channel enables in bits 3:0, the compare-inhibit test bit in bit 6 and the readback-select test bit in bit 7; bits 5:4 read 0.
- R5: `ch_tick[i]` is high only in a cycle where `s_tick` is high. It is high in that cycle exactly when enable bit i was set at the previous scaled-clock edge, so an enable change is picked up only at a scaled edge.
- R6: One cycle after the enable register or `ddr_in` changes, `pin_oe` equals enable OR `ddr_in`, and `pin_pwm_sel` equals the enable bits.
- R7: While `test_mode` is 0, writes to enable bits 7:6 are ignored: they read back 0 and `cmp_reset_inhibit` stays 0.
- R8: With readback select (bit 7) set, a divisor read returns the scaled-clock level in bit 0 and zeros in bits 7:1. Divisor writes still take effect and read back once the select clears.
- R9: `cmp_reset_inhibit` equals the compare-inhibit test bit (enable register bit 6) written under `test_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | Allows writes to the test bits |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects divisor, 1 selects enable register |
| wr_data | input | 8 | Write data |
| ddr_in | input | 4 | Stored data-direction bits of the channel pins |
| rd_data | output | 8 | Registered read data |
| s_tick | output | 1 | Scaled-clock tick, one cycle wide |
| ch_tick | output | 4 | Per-channel gated count strobes |
| pin_oe | output | 4 | Effective pin output enable |
| pin_pwm_sel | output | 4 | Selects the PWM waveform onto the pin |
| cmp_reset_inhibit | output | 1 | Suppresses counter reset on period match |

## Verification
The divisor is swept over 1 to 20, several larger values and 0. Each tick interval is measured against 2*d, which separates an off-by-one in the terminal count from a missing divide-by-two and from the zero-means-256 case. All sixteen enable patterns are applied with a short divisor while every cycle's strobes are compared with a bench model that latches enables only on scaled edges. This exposes gating that is immediate or delayed by the wrong amount. All 256 pairs of enable and direction values check the pin-direction merge. Test-bit writes made with and without `test_mode` show whether the gating holds.

// File: rtl/pwmfe_pkg.sv
package pwmfe_pkg;
  typedef enum logic {SEL_DIV = 1'b0, SEL_EN = 1'b1} reg_sel_e;
  localparam int RDSEL_BIT   = 7;
  localparam int INHIBIT_BIT = 6;
endpackage

// File: rtl/pwmfe_prescaler.sv
module pwmfe_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  output logic             s_edge,
  output logic             s_tick,
  output logic             s_level
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] active;
  logic [DIV_W-1:0] limit;
  logic             tc;

  // zero divisor wraps the full counter range (2**DIV_W)
  assign limit  = (active == '0) ? '1 : active - 1'b1;
  assign tc     = (cnt == limit);
  assign s_edge = tc & s_level;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      active  <= '0;
      s_level <= 1'b0;
      s_tick  <= 1'b0;
    end else begin
      s_tick <= s_edge;
      if (tc) begin
        cnt     <= '0;
        active  <= div_val;
        s_level <= ~s_level;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst) cnt <= limit);
  p_tick_single_r1: assert property (@(posedge clk) disable iff (rst) s_tick |=> !s_tick);
  p_level_flip_r2: assert property (@(posedge clk) disable iff (rst)
    tc |=> (s_level != $past(s_level)));
endmodule

// File: rtl/pwmfe_chgate.sv
module pwmfe_chgate (
  input  logic clk,
  input  logic rst,
  input  logic s_edge,
  input  logic en_req,
  output logic strobe
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      strobe <= 1'b0;
    end else begin
      strobe <= s_edge & en_q;
      if (s_edge) en_q <= en_req;
    end
  end

  p_gate_only_on_edge_r5: assert property (@(posedge clk) disable iff (rst)
    !s_edge |=> !strobe);
endmodule

// File: rtl/pwm_clkfront.sv
module pwm_clkfront #(
  parameter int DIV_W = 8,
  parameter int NCH   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             test_mode,
  input  logic             wr_en,
  input  logic             reg_sel,
  input  logic [DIV_W-1:0] wr_data,
  input  logic [NCH-1:0]   ddr_in,
  output logic [DIV_W-1:0] rd_data,
  output logic             s_tick,
  output logic [NCH-1:0]   ch_tick,
  output logic [NCH-1:0]   pin_oe,
  output logic [NCH-1:0]   pin_pwm_sel,
  output logic             cmp_reset_inhibit
);
  import pwmfe_pkg::*;

  localparam int LVL_PAD = DIV_W - 1;

  reg_sel_e         sel;
  logic [DIV_W-1:0] div_reg;
  logic [NCH-1:0]   en_reg;
  logic             rdsel_q;
  logic             inhib_q;
  logic             s_edge;
  logic             s_level;
  logic [DIV_W-1:0] en_image;

  assign sel = reg_sel_e'(reg_sel);
  assign cmp_reset_inhibit = inhib_q;

  always_comb begin
    en_image              = '0;
    en_image[NCH-1:0]     = en_reg;
    en_image[RDSEL_BIT]   = rdsel_q;
    en_image[INHIBIT_BIT] = inhib_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_reg     <= '0;
      en_reg      <= '0;
      rdsel_q     <= 1'b0;
      inhib_q     <= 1'b0;
      rd_data     <= '0;
      pin_oe      <= '0;
      pin_pwm_sel <= '0;
    end else begin
      if (wr_en && sel == SEL_DIV) div_reg <= wr_data;
      if (wr_en && sel == SEL_EN)  en_reg  <= wr_data[NCH-1:0];
      if (!test_mode) begin
        rdsel_q <= 1'b0;
        inhib_q <= 1'b0;
      end else if (wr_en && sel == SEL_EN) begin
        rdsel_q <= wr_data[RDSEL_BIT];
        inhib_q <= wr_data[INHIBIT_BIT];
      end
      if (sel == SEL_EN)  rd_data <= en_image;
      else if (rdsel_q)   rd_data <= {{LVL_PAD{1'b0}}, s_level};
      else                rd_data <= div_reg;
      pin_oe      <= en_reg | ddr_in;
      pin_pwm_sel <= en_reg;
    end
  end

  pwmfe_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .div_val(div_reg),
    .s_edge(s_edge), .s_tick(s_tick), .s_level(s_level)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwmfe_chgate u_gate (
      .clk(clk), .rst(rst), .s_edge(s_edge),
      .en_req(en_reg[i]), .strobe(ch_tick[i])
    );
  end

  p_strobe_in_tick_r5: assert property (@(posedge clk) disable iff (rst)
    (|ch_tick) |-> s_tick);
  p_sel_implies_oe_r6: assert property (@(posedge clk) disable iff (rst)
    (pin_pwm_sel & ~pin_oe) == '0);
  p_test_gated_r7: assert property (@(posedge clk) disable iff (rst)
    !test_mode |=> !cmp_reset_inhibit);
endmodule

// File: tb/pwm_clkfront_bench.sv
module pwm_clkfront_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       test_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [3:0] ddr_in = '0;
  logic [7:0] rd_data;
  logic       s_tick;
  logic [3:0] ch_tick, pin_oe, pin_pwm_sel;
  logic       cmp_reset_inhibit;

  int checks = 0;
  int errors = 0;
  logic [3:0] mirror_en = '0;
  logic [3:0] lat = '0;

  always #5 clk = ~clk;

  pwm_clkfront u_pwm_clkfront (
    .clk(clk), .rst(rst), .test_mode(test_mode), .wr_en(wr_en),
    .reg_sel(reg_sel), .wr_data(wr_data), .ddr_in(ddr_in),
    .rd_data(rd_data), .s_tick(s_tick), .ch_tick(ch_tick),
    .pin_oe(pin_oe), .pin_pwm_sel(pin_pwm_sel),
    .cmp_reset_inhibit(cmp_reset_inhibit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle; strobe model for R5
  task automatic step();
    @(negedge clk);
    if (s_tick) begin
      chk(ch_tick == lat, "R5", ch_tick, lat);
      lat = mirror_en;
    end else begin
      chk(ch_tick == 4'd0, "R5", ch_tick, 0);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; reg_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
    if (sel) mirror_en = d[3:0];
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    reg_sel = sel;
    step();
    v = rd_data;
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!s_tick && n < 2000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n, d, exp;
    bit seen0, seen1, bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3 reset state
    chk(s_tick == 0 && ch_tick == 0, "R3", {s_tick, ch_tick}, 0);
    chk(pin_oe == 0 && pin_pwm_sel == 0, "R3", {pin_oe, pin_pwm_sel}, 0);
    chk(cmp_reset_inhibit == 0, "R3", cmp_reset_inhibit, 0);
    rd(1'b0, v); chk(v == 8'h00, "R3", v, 0);
    rd(1'b1, v); chk(v == 8'h00, "R3", v, 0);
    // R3/R2 default divisor 0 -> 512
    wait_tick(n); wait_tick(n);
    chk(n == 512, "R2", n, 512);

    // R1/R2 divisor sweep
    for (int k = 0; k < 24; k++) begin
      d = (k < 20) ? k + 1 : (k == 20) ? 64 : (k == 21) ? 128 : (k == 22) ? 255 : 0;
      exp = 2 * ((d == 0) ? 256 : d);
      wr(1'b0, d[7:0]);
      rd(1'b0, v); chk(v == d[7:0], "R4", v, d);
      wait_tick(n); wait_tick(n); wait_tick(n);
      wait_tick(n); chk(n == exp, (d == 0) ? "R2" : "R1", n, exp);
      step(); chk(s_tick == 0, "R1", s_tick, 0);
      wait_tick(n); chk(n == exp - 1, (d == 0) ? "R2" : "R1", n + 1, exp);
    end

    // R5 enable gating with short period
    wr(1'b0, 8'd2);
    repeat (20) step();
    for (int p = 0; p < 16; p++) begin
      wr(1'b1, {4'd0, p[3:0]});
      repeat (7 + p) step();
      rd(1'b1, v); chk(v == {4'd0, p[3:0]}, "R4", v, p);
    end
    wr(1'b1, 8'h00);
    repeat (12) step();

    // R6 direction merge sweep
    for (int e = 0; e < 16; e++) begin
      for (int dd = 0; dd < 16; dd++) begin
        ddr_in = dd[3:0];
        wr(1'b1, {4'd0, e[3:0]});
        step();
        chk(pin_oe == (e[3:0] | dd[3:0]), "R6", pin_oe, e | dd);
        chk(pin_pwm_sel == e[3:0], "R6", pin_pwm_sel, e);
      end
    end
    wr(1'b1, 8'h00);
    ddr_in = 4'h0;

    // R7 test bits ignored without test_mode
    test_mode = 1'b0;
    wr(1'b1, 8'hF0);
    mirror_en = 4'h0;
    step();
    rd(1'b1, v); chk(v == 8'h00, "R7", v, 0);
    chk(cmp_reset_inhibit == 0, "R7", cmp_reset_inhibit, 0);
    wr(1'b0, 8'd3);
    rd(1'b0, v); chk(v == 8'd3, "R7", v, 3);

    // R9 inhibit under test_mode
    test_mode = 1'b1;
    wr(1'b1, 8'h40);
    step();
    chk(cmp_reset_inhibit == 1, "R9", cmp_reset_inhibit, 1);
    rd(1'b1, v); chk(v == 8'h40, "R4", v, 8'h40);
    wr(1'b1, 8'h00);
    step();
    chk(cmp_reset_inhibit == 0, "R9", cmp_reset_inhibit, 0);

    // R8 scaled level readback
    wr(1'b1, 8'h80);
    reg_sel = 1'b0;
    seen0 = 0; seen1 = 0; bad = 0;
    step();
    for (int c = 0; c < 20; c++) begin
      step();
      if (rd_data[7:1] != 0) bad = 1;
      if (rd_data[0]) seen1 = 1; else seen0 = 1;
    end
    chk(!bad, "R8", bad, 0);
    chk(seen0 && seen1, "R8", {seen0, seen1}, 3);
    wr(1'b0, 8'd5);
    wr(1'b1, 8'h00);
    step();
    rd(1'b0, v); chk(v == 8'd5, "R8", v, 5);
    test_mode = 1'b0;
    repeat (2) step();
    chk(cmp_reset_inhibit == 0, "R7", cmp_reset_inhibit, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule